// File: doc/BRIEF.md
# Microwire Serial Master Controller

This block is a memory-mapped serial master for three-wire Microwire-style peripherals. Software loads a transmit word into the data register and writes a command to the control/status register. The command gives a write bit count, a read bit count, one of four chip selects, the chip-select assert or release command, and a start bit. The block then shifts the left-aligned transmit bits out on `sdo` and clocks the read bits in from `sdi`. The received bits land right-aligned in the data register. The block drives the serial clock and the four chip-select lines throughout.

Each chip select has its own 6-bit setup field, which holds:
- the edge used to sample read data;
- the edge used to launch write data;
- the active level of the chip-select line;
- a clock divide of 2, 4 or 8.

A shared clock setup register holds the serial clock enable and a prescale of 2, 4, 7 or 10. Chip select is a level that software controls. It is asserted or released by a command bit, and it holds its last commanded state between transfers. Progress is reported through a busy flag and a read-ready flag.

Top module: `uw_master`

## Requirements
- R1: After reset, every register reads 0. All four chip-select lines sit at their inactive level, which is high because a zero level bit means active-low. `sclk` and `sdo` are low.
- R2: The register bus has these word addresses:
  - 0: data.
  - 1: control/status.
  - 2: setup A. Chip select 0 uses bits [5:0] and chip select 1 uses bits [11:6].
  - 3: setup B. Chip select 2 uses bits [5:0] and chip select 3 uses bits [11:6].
  - 4: clock setup. Bit 0 is the enable. Bits [2:1] give the prescale: 0 means 2, 1 means 4, 2 means 7 and 3 means 10.

  The setup registers read back 12 bits and the clock register reads back 3 bits. All higher bits read as 0.
- R3: Control/status has these fields:
  - [4:0]: read bit count.
  - [9:5]: write bit count.
  - [11:10]: chip-select index.
  - 12: assert command.
  - 13: start.

  On a read, bits [12:0] return the last accepted fields, bit 13 reads 0, bit 14 is busy and bit 15 is read-ready.
- R4: A transfer with write count W sends data bits [15:16-W] on `sdo`, most significant bit first. `sdo` is low whenever no transfer is active.
- R5: A transfer with read count R (1 to 16) shifts R bits in, most significant bit first. It places them right-aligned in the data register with zeros above. It sets read-ready at the end of the transfer. A read of the data register clears read-ready.
- R6: Busy rises on the clock edge that accepts a start and falls after the last bit. A start with both counts at 0 holds busy for exactly one cycle and does not set read-ready.
- R7: A control/status write sets the chip select named by bits [11:10] to asserted (bit 12 = 1) or released (bit 12 = 0). The other chip selects keep their state, and the state holds between transfers. Setup bit 2 = 1 makes the line active-high, and 0 makes it active-low.
- R8: Setup bit 1 = 1 launches write data on falling `sclk` edges, with the first bit presented at start. With bit 1 = 0, write data launches on rising edges. Setup bit 0 = 1 samples `sdi` on falling edges, and 0 samples it on rising edges.
- R9: `sclk` idles low. Each bit is a low phase followed by a high phase, and the transfer has exactly W+R rising edges. The high phase lasts floor(P/2)·D clock cycles and the low phase lasts ceil(P/2)·D. P is the prescale. D comes from setup bits [4:3]: 0 means 2, 1 means 4, and 2 or 3 means 8.
- R10: A control/status write while busy is high is ignored. Its fields, its chip-select command and its start have no effect.
- R11: With the clock enable at 0, an active transfer freezes: `sclk` does not toggle and busy stays high. The transfer resumes when the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only on the data register) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines, each at its configured active level |

## Verification
Each kind of wrong internal state shows at the ports within a bounded time:
- A wrong phase counter or prescale decode shows at once as a wrong `sclk` high or low length, at most one bit period after the fault.
- A wrong bit counter shows at the end of the transfer as a wrong number of rising edges, or as busy falling early or late.
- A shift register that is off by one position shows in the bits captured from `sdo`, or in the right-aligned word read back, as soon as the transfer ends.
- Chip-select state that leaks between indices, or that changes while busy, shows on `cs_line` on the cycle after the write.

// File: rtl/uw_pkg.sv
package uw_pkg;

  // per-chip-select setup, 5 significant bits of the 6-bit field
  typedef struct packed {
    logic [1:0] div;
    logic       act_hi;
    logic       wr_fall;
    logic       rd_fall;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_FIN} xfer_st_e;

  // system clocks per prescaled tick
  function automatic logic [3:0] div_cycles(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // ticks in the low phase: ceil(P/2) for P = 2,4,7,10
  function automatic logic [2:0] lo_ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // ticks in the high phase: floor(P/2)
  function automatic logic [2:0] hi_ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/uw_tick_gen.sv
module uw_tick_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int CW = 3;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    lim;
  logic          wrap;

  assign lim  = uw_pkg::div_cycles(div_sel);
  assign wrap = ({1'b0, cnt_q} == (lim - 4'd1));
  assign tick = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uw_shift_eng.sv
module uw_shift_eng #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  wbits,
  input  logic [CNT_W-1:0]  rbits,
  input  logic [DATA_W-1:0] tx_word,
  input  uw_pkg::cs_cfg_t   cfg_in,
  input  logic [1:0]        pre_in,
  input  logic              tick,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              sdo,
  output logic [1:0]        div_sel,
  output logic [DATA_W-1:0] rx_word
);
  import uw_pkg::*;
  localparam int BIT_W = CNT_W + 1;

  xfer_st_e          st_q, st_d;
  logic [2:0]        pc_q, pc_d;
  logic [BIT_W-1:0]  bit_q, bit_d, tot_q, tot_d, wn_q, wn_d, sum;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              sdo_q, sdo_d;
  cs_cfg_t           cfg_q, cfg_d;
  logic [1:0]        pre_q, pre_d;
  logic [2:0]        lo_lim, hi_lim;
  logic              in_write, in_read, next_write;

  assign lo_lim     = lo_ticks(pre_q);
  assign hi_lim     = hi_ticks(pre_q);
  assign sum        = {1'b0, wbits} + {1'b0, rbits};
  assign in_write   = (bit_q < wn_q);
  assign in_read    = !in_write;
  assign next_write = ((bit_q + 1'b1) < wn_q);

  always_comb begin
    st_d = st_q; pc_d = pc_q; bit_d = bit_q; tot_d = tot_q; wn_d = wn_q;
    tx_d = tx_q; rx_d = rx_q; sdo_d = sdo_q; cfg_d = cfg_q; pre_d = pre_q;
    case (st_q)
      ST_IDLE: if (start) begin
        cfg_d = cfg_in; pre_d = pre_in;
        wn_d  = {1'b0, wbits}; tot_d = sum;
        bit_d = '0; pc_d = '0; rx_d = '0;
        if (wbits != '0 && cfg_in.wr_fall) begin
          sdo_d = tx_word[DATA_W-1];
          tx_d  = {tx_word[DATA_W-2:0], 1'b0};
        end else begin
          tx_d  = tx_word;
        end
        st_d = (sum == '0) ? ST_FIN : ST_LOW;
      end
      ST_LOW: if (tick) begin
        if (pc_q == lo_lim - 3'd1) begin
          pc_d = '0;
          st_d = ST_HIGH;
          if (in_write && !cfg_q.wr_fall) begin
            sdo_d = tx_q[DATA_W-1];
            tx_d  = {tx_q[DATA_W-2:0], 1'b0};
          end
          if (in_read && !cfg_q.rd_fall) rx_d = {rx_q[DATA_W-2:0], sdi};
        end else begin
          pc_d = pc_q + 3'd1;
        end
      end
      ST_HIGH: if (tick) begin
        if (pc_q == hi_lim - 3'd1) begin
          pc_d = '0;
          if (in_read && cfg_q.rd_fall) rx_d = {rx_q[DATA_W-2:0], sdi};
          if (bit_q == tot_q - 1'b1) begin
            st_d = ST_FIN;
          end else begin
            bit_d = bit_q + 1'b1;
            st_d  = ST_LOW;
            if (next_write && cfg_q.wr_fall) begin
              sdo_d = tx_q[DATA_W-1];
              tx_d  = {tx_q[DATA_W-2:0], 1'b0};
            end
          end
        end else begin
          pc_d = pc_q + 3'd1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        sdo_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; pc_q <= '0; bit_q <= '0; tot_q <= '0; wn_q <= '0;
      tx_q <= '0; rx_q <= '0; sdo_q <= 1'b0; cfg_q <= '0; pre_q <= '0;
    end else begin
      st_q <= st_d; pc_q <= pc_d; bit_q <= bit_d; tot_q <= tot_d; wn_q <= wn_d;
      tx_q <= tx_d; rx_q <= rx_d; sdo_q <= sdo_d; cfg_q <= cfg_d; pre_q <= pre_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_FIN);
  assign sclk    = (st_q == ST_HIGH);
  assign sdo     = sdo_q;
  assign div_sel = cfg_q.div;
  assign rx_word = rx_q;

  // R9: the phase counter never passes the low-phase length
  assert_phase_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW) |-> (pc_q < lo_lim));
  // R4: data output quiet outside a transfer
  assert_sdo_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sdo);

endmodule

// File: rtl/uw_master.sv
module uw_master #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [3:0]        cs_line
);
  import uw_pkg::*;
  localparam int NUM_CS  = 4;
  localparam int IDX_W   = $clog2(NUM_CS);
  localparam int CFG_W   = 6;
  localparam int SETUP_W = 2 * CFG_W;
  localparam int CNT_W   = $clog2(DATA_W) + 1;
  localparam int CLK_W   = 3;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [DATA_W-1:0]  data_q, data_d;
  logic [CNT_W-1:0]   rcnt_q, rcnt_d, wcnt_q, wcnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_new;
  logic               cmd_q, cmd_d, rdrdy_q, rdrdy_d;
  logic [SETUP_W-1:0] setup_q [2];
  logic [SETUP_W-1:0] setup_d [2];
  logic [CLK_W-1:0]   clk_q, clk_d;
  logic [NUM_CS-1:0]  cs_act_q, cs_act_d;

  logic busy, done, tick, start;
  logic wr_data, wr_csr, wr_clk, rd_data;
  logic [1:0] wr_setup, div_sel;
  logic [DATA_W-1:0] rx_word;
  cs_cfg_t cfg_arr [NUM_CS];

  assign idx_new  = bus_wdata[11:10];
  assign wr_data  = bus_wr && (bus_addr == 3'd0);
  assign wr_csr   = bus_wr && (bus_addr == 3'd1) && !busy;
  assign wr_setup = {bus_wr && (bus_addr == 3'd3), bus_wr && (bus_addr == 3'd2)};
  assign wr_clk   = bus_wr && (bus_addr == 3'd4);
  assign rd_data  = bus_rd && (bus_addr == 3'd0);
  assign start    = wr_csr && bus_wdata[13];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cfg_arr[g] = cs_cfg_t'(setup_q[g / 2][(g % 2) * CFG_W +: CFG_W - 1]);
    assign cs_line[g] = cfg_arr[g].act_hi ? cs_act_q[g] : ~cs_act_q[g];
  end

  always_comb begin
    data_d = data_q; rcnt_d = rcnt_q; wcnt_d = wcnt_q; idx_d = idx_q;
    cmd_d = cmd_q; rdrdy_d = rdrdy_q; clk_d = clk_q; cs_act_d = cs_act_q;
    setup_d = setup_q;
    if (wr_data) data_d = bus_wdata;
    if (rd_data) rdrdy_d = 1'b0;
    if (done && rcnt_q != '0) begin
      data_d  = rx_word;
      rdrdy_d = 1'b1;
    end
    if (wr_csr) begin
      rcnt_d = bus_wdata[4:0];
      wcnt_d = bus_wdata[9:5];
      idx_d  = idx_new;
      cmd_d  = bus_wdata[12];
      cs_act_d[idx_new] = bus_wdata[12];
    end
    for (int k = 0; k < 2; k++)
      if (wr_setup[k]) setup_d[k] = bus_wdata[SETUP_W-1:0];
    if (wr_clk) clk_d = bus_wdata[CLK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      data_q <= '0; rcnt_q <= '0; wcnt_q <= '0; idx_q <= '0; cmd_q <= 1'b0;
      rdrdy_q <= 1'b0; clk_q <= '0; cs_act_q <= '0;
      setup_q[0] <= '0; setup_q[1] <= '0;
    end else begin
      data_q <= data_d; rcnt_q <= rcnt_d; wcnt_q <= wcnt_d; idx_q <= idx_d;
      cmd_q <= cmd_d; rdrdy_q <= rdrdy_d; clk_q <= clk_d; cs_act_q <= cs_act_d;
      setup_q[0] <= setup_d[0]; setup_q[1] <= setup_d[1];
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = data_q;
      3'd1:    bus_rdata = {rdrdy_q, busy, 1'b0, cmd_q, idx_q, wcnt_q, rcnt_q};
      3'd2:    bus_rdata = {{(DATA_W-SETUP_W){1'b0}}, setup_q[0]};
      3'd3:    bus_rdata = {{(DATA_W-SETUP_W){1'b0}}, setup_q[1]};
      3'd4:    bus_rdata = {{(DATA_W-CLK_W){1'b0}}, clk_q};
      default: bus_rdata = '0;
    endcase
  end

  uw_tick_gen u_tick (
    .clk(clk), .rst_n(rst_s), .run(busy && clk_q[0]), .div_sel(div_sel), .tick(tick)
  );

  uw_shift_eng #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_s), .start(start),
    .wbits(bus_wdata[9:5]), .rbits(bus_wdata[4:0]), .tx_word(data_q),
    .cfg_in(cfg_arr[idx_new]), .pre_in(clk_q[2:1]), .tick(tick), .sdi(sdi),
    .busy(busy), .done(done), .sclk(sclk), .sdo(sdo), .div_sel(div_sel),
    .rx_word(rx_word)
  );

  // R10: command fields frozen while busy
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && bus_wr && bus_addr == 3'd1) |=>
      ($stable(idx_q) && $stable(wcnt_q) && $stable(rcnt_q) && $stable(cmd_q)));
  // R7: chip-select state cannot move during a transfer
  assert_cs_hold_R7: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> $stable(cs_act_q));
  // R5: a data read clears read-ready unless a completion lands
  assert_rdrdy_clear_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_data && !done) |=> !rdrdy_q);
  // R11: no serial clock movement with the enable off
  assert_noclk_R11: assert property (@(posedge clk) disable iff (!rst_s)
    !clk_q[0] |=> $stable(sclk));

endmodule

// File: tb/sim_uw_master.sv
module sim_uw_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, sdi = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        sclk, sdo;
  logic [3:0]  cs_line;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uw_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_line(cs_line));

  // vector: tx[50:35] rxpat[34:19] cs[18:17] w[16:12] r[11:7] pre[6:5] div[4:3] wrf[2] rdf[1] acthi[0]
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {16'hB380, 16'h0000, 2'd0, 5'd9,  5'd0,  2'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    {16'hA500, 16'h005A, 2'd1, 5'd8,  5'd8,  2'd2, 2'd0, 1'b1, 1'b0, 1'b1},
    {16'h0000, 16'h0ABC, 2'd2, 5'd0,  5'd12, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0},
    {16'h8001, 16'h0000, 2'd3, 5'd16, 5'd0,  2'd3, 2'd2, 1'b1, 1'b1, 1'b1},
    {16'hF000, 16'h9669, 2'd0, 5'd4,  5'd16, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'h0001, 2'd1, 5'd1,  5'd1,  2'd2, 2'd3, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    bus_addr = 3'd1;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (!bus_rdata[14]) break;
    end
  endtask

  task automatic run_vec(input logic [50:0] v);
    logic [15:0] tx, rx, rd;
    logic [1:0]  cs, pre, dv;
    int w, r, p, d, hi, lo, nr, nf, run, bad_hi, bad_lo;
    logic wrf, rdf, ah, prev, s, cs_ok;
    logic [31:0] cap, exp_rx;
    logic [5:0] f;
    tx = v[50:35]; rx = v[34:19]; cs = v[18:17]; w = int'(v[16:12]); r = int'(v[11:7]);
    pre = v[6:5]; dv = v[4:3]; wrf = v[2]; rdf = v[1]; ah = v[0];
    p  = (pre == 0) ? 2 : (pre == 1) ? 4 : (pre == 2) ? 7 : 10;
    d  = (dv == 0) ? 2 : (dv == 1) ? 4 : 8;
    hi = p / 2; lo = p - hi;
    f = {1'b0, dv, ah, wrf, rdf};
    bus_write(3'd2 + {2'b0, cs[1]}, cs[0] ? {4'b0, f, 6'b0} : {10'b0, f});
    bus_write(3'd4, {13'b0, pre, 1'b1});
    bus_write(3'd0, tx);
    sdi = (w == 0 && r > 0) ? rx[r-1] : 1'b0;
    bus_write(3'd1, {2'b00, 1'b1, 1'b1, cs, w[4:0], r[4:0]});
    bus_addr = 3'd1;
    nr = 0; nf = 0; run = 0; bad_hi = 0; bad_lo = 0; prev = 1'b0; cap = 0; cs_ok = 1'b1;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      run++; s = sclk;
      if (s && !prev) begin
        if (nf > 0 && run != lo * d) bad_lo++;
        if (cs_line[cs] !== ah) cs_ok = 1'b0;
        if (wrf && nr < w) cap = {cap[30:0], sdo};
        if (rdf && nr >= w && nr < w + r) sdi = rx[r-1-(nr-w)];
        nr++; run = 0;
      end else if (!s && prev) begin
        if (run != hi * d) bad_hi++;
        if (!wrf && nf < w) cap = {cap[30:0], sdo};
        nf++;
        if (!rdf && nf >= w && nf < w + r) sdi = rx[r-1-(nf-w)];
        run = 0;
      end
      prev = s;
      if (!bus_rdata[14]) break;
    end
    chk("R6 busy falls after transfer", {31'b0, bus_rdata[14]}, 0);
    chk("R9 rising edge count", nr, w + r);
    chk("R9 high phase length mismatches", bad_hi, 0);
    chk("R9 low phase length mismatches", bad_lo, 0);
    chk("R7 chip select active during transfer", {31'b0, cs_ok}, 1);
    chk("R8 R4 transmitted bits", cap, (w > 0) ? ({16'b0, tx} >> (16 - w)) : 32'd0);
    chk("R7 chip select held after transfer", {31'b0, cs_line[cs]}, {31'b0, ah});
    chk("R3 control readback", {18'b0, bus_rdata[13:0]}, {18'b0, 2'b01, cs, w[4:0], r[4:0]});
    if (r > 0) begin
      exp_rx = (r == 16) ? {16'b0, rx} : ({16'b0, rx} & ((32'd1 << r) - 1));
      chk("R5 read-ready set", {31'b0, bus_rdata[15]}, 1);
      bus_read(3'd0, rd);
      chk("R8 R5 received word", {16'b0, rd}, exp_rx);
      bus_read(3'd1, rd);
      chk("R5 read-ready cleared by data read", {31'b0, rd[15]}, 0);
    end
    bus_write(3'd1, {4'b0000, cs, 10'b0});
    #1 chk("R7 chip select released", {31'b0, cs_line[cs]}, {31'b0, ~ah});
    sdi = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(3'd1, rd); chk("R1 control reset", {16'b0, rd}, 0);
    bus_read(3'd0, rd); chk("R1 data reset", {16'b0, rd}, 0);
    bus_read(3'd2, rd); chk("R1 setup A reset", {16'b0, rd}, 0);
    bus_read(3'd4, rd); chk("R1 clock reset", {16'b0, rd}, 0);
    chk("R1 lines idle", {26'b0, cs_line, sclk, sdo}, {26'b0, 4'hF, 2'b00});
    // R2 register map widths
    bus_write(3'd2, 16'hFABC); bus_read(3'd2, rd); chk("R2 setup A readback", {16'b0, rd}, 32'h0ABC);
    bus_write(3'd3, 16'h1234); bus_read(3'd3, rd); chk("R2 setup B readback", {16'b0, rd}, 32'h0234);
    bus_write(3'd4, 16'hFFFF); bus_read(3'd4, rd); chk("R2 clock readback", {16'b0, rd}, 32'h0007);
    bus_write(3'd2, 16'h0); bus_write(3'd3, 16'h0);
    // R7 command without start, per index
    bus_write(3'd1, 16'h1800);
    #1 chk("R7 assert index 2 only", {28'b0, cs_line}, 32'hB);
    bus_write(3'd1, 16'h0800);
    #1 chk("R7 release index 2", {28'b0, cs_line}, 32'hF);
    // table-driven transfers
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R6 zero-length start
    bus_write(3'd2, 16'h0); bus_write(3'd4, 16'h1);
    bus_write(3'd1, 16'h2000);
    #1 chk("R6 zero transfer busy one cycle", {31'b0, bus_rdata[14]}, 1);
    @(negedge clk); #1 chk("R6 zero transfer busy cleared", {30'b0, bus_rdata[15:14]}, 0);
    // R10 write while busy ignored
    bus_write(3'd2, 16'h0010); bus_write(3'd4, 16'h0007); bus_write(3'd0, 16'h1234);
    bus_write(3'd1, 16'h3200);
    bus_write(3'd1, 16'h3863);
    bus_read(3'd1, rd); chk("R10 control unchanged while busy", {16'b0, rd}, 32'h5200);
    chk("R10 chip select 2 untouched", {31'b0, cs_line[2]}, 1);
    wait_idle();
    chk("R10 transfer completes", {31'b0, bus_rdata[14]}, 0);
    bus_write(3'd1, 16'h0000);
    // R11 clock disabled freezes
    bus_write(3'd4, 16'h0000); bus_write(3'd0, 16'hF000);
    bus_write(3'd1, 16'h2080);
    highs = 0; bus_addr = 3'd1;
    for (int t = 0; t < 60; t++) begin @(negedge clk); if (sclk) highs++; end
    chk("R11 no serial clock while disabled", highs, 0);
    chk("R11 busy held while disabled", {31'b0, bus_rdata[14]}, 1);
    bus_write(3'd4, 16'h0001);
    wait_idle();
    chk("R11 resumes and completes", {31'b0, bus_rdata[14]}, 0);
    chk("R4 sdo low when idle", {31'b0, sdo}, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule